// File: doc/BRIEF.md
# LCD Status Interrupt Request Generator

This block turns the display controller's state into the LCD-status interrupt request for the processor's interrupt controller. A separate display timing engine supplies the current scanline number and the 2-bit display mode. The line compare value also arrives as an input. Software sets four select bits through a one-byte status register. Each select bit enables one source:

- line coincidence;
- horizontal blank;
- vertical blank;
- object memory search.

Each enabled source that is currently true feeds one combined condition, formed as an OR of all of them. The block raises a one-cycle request pulse only when that combined condition goes from false to true. A source that turns true while another enabled source is already true therefore adds no second request.

The same status byte reads back the select bits, a coincidence flag and the current display mode. Vertical blank starts after the 144th visible line. At that moment the interrupt controller also receives a separate vertical-blank request, which does not come from this block. This block only adds the optional status request on top of it.

Top module: `lcd_stat_irq`

## Requirements
- R1: After reset, `irq_pulse` is 0 and status bits 6:3 read 0, so no source is enabled.
- R2: When `line_cur` equals `line_cmp` and status bit 6 is 1, the combined condition is true. Status bit 2 reads 1 whenever the two values were equal at the previous clock edge, whatever the select bits are.
- R3: Mode 0 (horizontal blank) with status bit 3 set makes the combined condition true.
- R4: Mode 1 (vertical blank) with either status bit 4 or status bit 5 set makes the combined condition true.
- R5: Mode 2 (object memory search) with status bit 5 set makes the combined condition true. Mode 3 (pixel transfer) never contributes.
- R6: `irq_pulse` is 1 in the cycle after a clock edge at which the combined condition was true and was false at the edge before. A second source becoming true while another enabled source stays true raises no pulse.
- R7: The pulse lasts exactly one clock cycle, even when the condition stays true.
- R8: A status write changes only bits 6:3, which are taken from `wr_data[6:3]`. Bit 7 reads 0, bit 2 is the coincidence flag and bits 1:0 are the mode sampled at the last edge. All of these are read-only.
- R9: A source whose select bit is clear raises no pulse, even when its state is true.
- R10: Setting a select bit while its source is already true counts as a rising condition and raises one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_cur | input | LINE_W | Scanline currently being processed |
| line_cmp | input | LINE_W | Line compare value |
| disp_mode | input | 2 | Display mode: 0 hblank, 1 vblank, 2 search, 3 transfer |
| wr_en | input | 1 | Status register write strobe |
| wr_data | input | 8 | Status register write byte |
| stat_rd | output | 8 | Status register read byte |
| irq_pulse | output | 1 | One-cycle status interrupt request |

## Verification
Two sources can become true at the same clock edge. In the test, the mode switches to horizontal blank in the same cycle that the line reaches the compare value, with both sources enabled, and exactly one pulse must follow. In a second test, one source is held true while the other rises, and the bench checks that no extra request appears. A status write can also land in the same cycle as an already true source. That case is judged by a single pulse one cycle after the enable takes effect.

// File: rtl/lcd_stat_pkg.sv
package lcd_stat_pkg;

    localparam int SRC_N = 4;

    typedef enum logic [1:0] {
        MODE_HBLANK = 2'd0,
        MODE_VBLANK = 2'd1,
        MODE_SEARCH = 2'd2,
        MODE_XFER   = 2'd3
    } disp_mode_t;

    // Select bits in status-register order, bit 6 down to bit 3
    typedef struct packed {
        logic coin_en;
        logic srch_en;
        logic vb_en;
        logic hb_en;
    } stat_sel_t;

    typedef enum int {
        SRC_HB   = 0,
        SRC_VB   = 1,
        SRC_SRCH = 2,
        SRC_COIN = 3
    } src_idx_t;

    function automatic logic [SRC_N-1:0] src_hits(disp_mode_t m, logic coin);
        logic [SRC_N-1:0] h;
        h           = '0;
        h[SRC_HB]   = (m == MODE_HBLANK);
        h[SRC_VB]   = (m == MODE_VBLANK);
        h[SRC_SRCH] = (m == MODE_SEARCH);
        h[SRC_COIN] = coin;
        return h;
    endfunction

    function automatic logic [SRC_N-1:0] src_enables(stat_sel_t s);
        logic [SRC_N-1:0] e;
        e[SRC_HB]   = s.hb_en;
        e[SRC_VB]   = s.vb_en | s.srch_en;
        e[SRC_SRCH] = s.srch_en;
        e[SRC_COIN] = s.coin_en;
        return e;
    endfunction

endpackage

// File: rtl/lcd_stat_regs.sv
module lcd_stat_regs
    import lcd_stat_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  logic [7:0] wr_data,
    output stat_sel_t sel_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (wr_en) begin
            sel_q <= stat_sel_t'(wr_data[6:3]);
        end
    end

    // R8
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(sel_q));

    // R8
    sel_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_data[7] || wr_data[2:0] != 3'd0)) |=> (sel_q == $past(wr_data[6:3])));

endmodule

// File: rtl/lcd_stat_cond.sv
module lcd_stat_cond
    import lcd_stat_pkg::*;
#(
    parameter int LINE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] line_cur,
    input  logic [LINE_W-1:0] line_cmp,
    input  disp_mode_t        mode,
    input  stat_sel_t         sel,
    output logic              cond_now,
    output logic              coin_q,
    output disp_mode_t        mode_q
);

    logic             coin_now;
    logic [SRC_N-1:0] hits;
    logic [SRC_N-1:0] ens;
    logic [SRC_N-1:0] act;

    assign coin_now = (line_cur == line_cmp);
    assign hits     = src_hits(mode, coin_now);
    assign ens      = src_enables(sel);

    for (genvar i = 0; i < SRC_N; i++) begin : g_src
        assign act[i] = hits[i] & ens[i];
    end

    assign cond_now = |act;

    always_ff @(posedge clk) begin
        if (rst) begin
            coin_q <= 1'b0;
            mode_q <= MODE_HBLANK;
        end else begin
            coin_q <= coin_now;
            mode_q <= mode;
        end
    end

    // R5
    xfer_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_XFER && !(sel.coin_en && coin_now)) |-> !cond_now);

    // R9
    all_off_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == '0) |-> !cond_now);

endmodule

// File: rtl/lcd_stat_edge.sv
module lcd_stat_edge (
    input  logic clk,
    input  logic rst,
    input  logic cond_in,
    output logic pulse_q
);

    logic cond_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            cond_q  <= cond_in;
            pulse_q <= cond_in & ~cond_q;
        end
    end

    // R7
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_q |=> !pulse_q);

    // R6
    held_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cond_q && cond_in) |=> !pulse_q);

    // R6
    rise_fire_chk: assert property (@(posedge clk) disable iff (rst)
        (!cond_q && cond_in) |=> pulse_q);

endmodule

// File: rtl/lcd_stat_irq.sv
module lcd_stat_irq
    import lcd_stat_pkg::*;
#(
    parameter int LINE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] line_cur,
    input  logic [LINE_W-1:0] line_cmp,
    input  logic [1:0]        disp_mode,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        stat_rd,
    output logic              irq_pulse
);

    stat_sel_t  sel_q;
    logic       cond_now;
    logic       coin_q;
    disp_mode_t mode_q;

    lcd_stat_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .sel_q   (sel_q)
    );

    lcd_stat_cond #(.LINE_W(LINE_W)) u_cond (
        .clk      (clk),
        .rst      (rst),
        .line_cur (line_cur),
        .line_cmp (line_cmp),
        .mode     (disp_mode_t'(disp_mode)),
        .sel      (sel_q),
        .cond_now (cond_now),
        .coin_q   (coin_q),
        .mode_q   (mode_q)
    );

    lcd_stat_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .cond_in (cond_now),
        .pulse_q (irq_pulse)
    );

    assign stat_rd = {1'b0, sel_q, coin_q, mode_q};

    // R2
    coin_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_q == stat_sel_t'(4'b1000) && disp_mode == 2'd3 && line_cur == line_cmp && !$past(line_cur == line_cmp))
        |=> irq_pulse);

    // R8
    top_bit_chk: assert property (@(posedge clk) disable iff (rst)
        stat_rd[7] == 1'b0);

endmodule

// File: tb/lcd_stat_irq_tb.sv
module lcd_stat_irq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [LW-1:0] line_cur = '0;
    logic [LW-1:0] line_cmp = 8'd100;
    logic [1:0]    disp_mode = 2'd3;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    stat_rd;
    logic          irq_pulse;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_stat_irq #(.LINE_W(LW)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .line_cur  (line_cur),
        .line_cmp  (line_cmp),
        .disp_mode (disp_mode),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .stat_rd   (stat_rd),
        .irq_pulse (irq_pulse)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_stat(logic [7:0] v);
        wr_en = 1'b1;
        wr_data = v;
        step();
        wr_en = 1'b0;
    endtask

    task automatic go_idle();
        disp_mode = 2'd3;
        line_cur = 8'd0;
        line_cmp = 8'd100;
        wr_stat(8'h00);
        step();
    endtask

    task automatic t_reset();
        chk("R1 irq", {7'd0, irq_pulse}, 8'd0);
        chk("R1 sel", {4'd0, stat_rd[6:3]}, 8'd0);
    endtask

    task automatic t_coin();
        go_idle();
        wr_stat(8'h40);
        line_cur = 8'd10; line_cmp = 8'd20;
        step();
        chk("R2 no match", {7'd0, irq_pulse}, 8'd0);
        line_cur = 8'd20;
        step();
        chk("R2 pulse", {7'd0, irq_pulse}, 8'd1);
        chk("R2 flag", {7'd0, stat_rd[2]}, 8'd1);
        step();
        chk("R7 one cycle", {7'd0, irq_pulse}, 8'd0);
        line_cur = 8'd21;
        step();
        chk("R2 flag clear", {7'd0, stat_rd[2]}, 8'd0);
        // flag visible with source disabled
        wr_stat(8'h00);
        line_cur = 8'd20;
        step();
        chk("R2 flag no enable", {7'd0, stat_rd[2]}, 8'd1);
        chk("R9 no pulse", {7'd0, irq_pulse}, 8'd0);
    endtask

    task automatic t_modes();
        go_idle();
        wr_stat(8'h08);
        disp_mode = 2'd0;
        step();
        chk("R3 hblank", {7'd0, irq_pulse}, 8'd1);
        go_idle();
        wr_stat(8'h10);
        disp_mode = 2'd1;
        step();
        chk("R4 vblank bit4", {7'd0, irq_pulse}, 8'd1);
        go_idle();
        wr_stat(8'h20);
        disp_mode = 2'd1;
        step();
        chk("R4 vblank bit5", {7'd0, irq_pulse}, 8'd1);
        disp_mode = 2'd3;
        step();
        disp_mode = 2'd2;
        step();
        chk("R5 search", {7'd0, irq_pulse}, 8'd1);
        go_idle();
        wr_stat(8'h38);
        disp_mode = 2'd3;
        step();
        chk("R5 transfer silent", {7'd0, irq_pulse}, 8'd0);
        go_idle();
        wr_stat(8'h40);
        disp_mode = 2'd0;
        step();
        chk("R9 hblank disabled", {7'd0, irq_pulse}, 8'd0);
        disp_mode = 2'd2;
        step();
        chk("R9 search disabled", {7'd0, irq_pulse}, 8'd0);
    endtask

    task automatic t_overlap();
        int pulses;
        go_idle();
        wr_stat(8'h48);
        disp_mode = 2'd0;
        step();
        chk("R6 first rise", {7'd0, irq_pulse}, 8'd1);
        line_cur = 8'd100;
        step();
        chk("R6 overlap no pulse", {7'd0, irq_pulse}, 8'd0);
        disp_mode = 2'd3;
        step();
        chk("R6 handover no pulse", {7'd0, irq_pulse}, 8'd0);
        line_cur = 8'd5;
        step();
        chk("R6 fall", {7'd0, irq_pulse}, 8'd0);
        disp_mode = 2'd0;
        line_cur = 8'd100;
        pulses = 0;
        for (int i = 0; i < 4; i++) begin
            step();
            if (irq_pulse) pulses++;
        end
        chk("R6 same-cycle single pulse", 8'(pulses), 8'd1);
    endtask

    task automatic t_enable_late();
        go_idle();
        disp_mode = 2'd0;
        step();
        wr_stat(8'h08);
        chk("R10 write cycle", {7'd0, irq_pulse}, 8'd0);
        step();
        chk("R10 pulse", {7'd0, irq_pulse}, 8'd1);
        step();
        chk("R7 held", {7'd0, irq_pulse}, 8'd0);
    endtask

    task automatic t_wr_mask();
        go_idle();
        disp_mode = 2'd2;
        line_cur = 8'd1; line_cmp = 8'd2;
        wr_stat(8'hFF);
        chk("R8 all ones", stat_rd, 8'h7A);
        wr_stat(8'h07);
        chk("R8 low bits ignored", stat_rd, 8'h02);
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        t_reset();
        t_coin();
        t_modes();
        t_overlap();
        t_enable_late();
        t_wr_mask();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule